// File: doc/BRIEF.md
# Bridge Downstream Address Routing Decoder

This block sits inside a host bridge and decides, for each host-initiated memory or I/O transaction, whether it is sent to the single-target secondary graphics bus or left on the default upstream hub port. Software programs an 8-bit bridge control word and four window registers through a small register write/read port. The control word holds a legacy-video enable, a legacy-ISA enable and a parity-error response enable. The window registers are an I/O base/limit pair and a memory base/limit pair. Each request strobe carries an address, a memory-or-I/O flag and a read-or-write flag. The block answers with a registered route decision one clock later.

The legacy-video ranges take priority over everything else. When the video enable is set, they claim accesses for the secondary bus. When the ISA enable is set, it carves the upper 768 bytes of every 1 KB block out of the I/O window. The block also makes master-aborted reads return all ones and drops master-aborted writes. It gates secondary-bus parity errors into the system-error request.

A two-state machine handles requests. `ST_IDLE` waits for a strobe. `ST_RESP` presents one cycle of valid route. The transitions are: `ST_IDLE -> ST_RESP` on a strobe; `ST_RESP -> ST_RESP` on a back-to-back strobe; `ST_RESP -> ST_IDLE` when there is no strobe.

Top module: `bridge_route_decoder`

## Requirements
- R1: The control register sits at reg_addr 0 and resets to 00h. Bit 3 (video enable), bit 2 (ISA enable) and bit 0 (parity response enable) are writable. Bits 7, 6, 5, 4 and 1 always read 0 and ignore writes. reg_rdata bits above 7 read 0 at this offset.
- R2: The window registers sit at reg_addr 1 (I/O base), 2 (I/O limit), 3 (memory base) and 4 (memory limit). Each holds 16 bits. Both bases reset to FFFFh and both limits reset to 0000h, so after reset no window matches. The memory registers hold address bits [31:16].
- R3: rsp_valid rises exactly one clock after each cycle with req_valid high, for one cycle per strobe. It stays low otherwise, including after reset. rsp_is_write echoes the strobe's req_is_write.
- R4: With video enable set, a memory access from 000A0000h to 000BFFFFh inclusive gives rsp_to_secondary = 1.
- R5: With video enable set, an I/O access gives rsp_to_secondary = 1 when address bits [9:0] are 3B0h–3BBh or 3C0h–3DFh. Bits [15:10] are ignored, so aliases match.
- R6: A video-range match routes to the secondary bus even when no window covers it and even when ISA enable is set.
- R7: With video enable clear, a video-range address goes to the hub (rsp_to_secondary = 0) unless a window covers it.
- R8: An I/O access matches the I/O window when base ≤ address[15:0] ≤ limit, inclusive at both ends.
- R9: With ISA enable set, an I/O access inside the window with address bits [9:8] ≠ 00 goes to the hub. With ISA enable clear, the whole window goes to the secondary bus.
- R10: A memory access matches the memory window when base ≤ address[31:16] ≤ limit, inclusive.
- R11: An access that matches no window and no enabled video range goes to the hub.
- R12: While sec_abort is high, host_rdata is all ones and sec_wr_commit is 0. Otherwise host_rdata equals sec_rdata and sec_wr_commit follows sec_wr_req.
- R13: serr_req = (sec_par_err AND parity response enable AND serr_enable) OR other_err.
- R14: A register write takes effect for the first request strobed after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data at reg_addr (combinational) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Transaction address |
| req_is_io | input | 1 | 1 = I/O access, 0 = memory access |
| req_is_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Route decision valid |
| rsp_to_secondary | output | 1 | 1 = secondary bus, 0 = hub port |
| rsp_is_write | output | 1 | Direction of the answered request |
| sec_abort | input | 1 | Current secondary transaction was master-aborted |
| sec_rdata | input | 32 | Read data from the secondary bus |
| host_rdata | output | 32 | Read data returned to the host |
| sec_wr_req | input | 1 | Write data presented to the secondary bus |
| sec_wr_commit | output | 1 | Write data is committed |
| sec_par_err | input | 1 | Address or data parity error seen on the secondary bus |
| serr_enable | input | 1 | System-wide SERR enable |
| other_err | input | 1 | Other error source requesting system error |
| serr_req | output | 1 | System-error request |

## Verification
The assertions watch several rules on every cycle. They check the one-cycle strobe-to-response timing and that the fixed-zero control bits stay zero. They check that aborts force all-ones read data and suppress write commits. They check the error gating, and that the video memory range is routed whenever it is enabled. What only the bench scenarios can show is the decode as a whole: inclusive window edges, ISA holes against aliases, the video range winning over a carved hole, and reset values read back through the register port. They also show a write taking effect on the next request.

// File: rtl/brd_pkg.sv
package brd_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } route_state_e;

    typedef struct packed {
        logic vga_en;
        logic isa_en;
        logic perr_en;
    } ctrl_t;

    localparam logic [2:0] OFS_CTRL     = 3'd0;
    localparam logic [2:0] OFS_IO_BASE  = 3'd1;
    localparam logic [2:0] OFS_IO_LIMIT = 3'd2;
    localparam logic [2:0] OFS_MEM_BASE = 3'd3;
    localparam logic [2:0] OFS_MEM_LIM  = 3'd4;

    localparam int CTRL_VGA_BIT  = 3;
    localparam int CTRL_ISA_BIT  = 2;
    localparam int CTRL_PERR_BIT = 0;

    localparam int VGA_IO_NUM = 2;
    localparam logic [9:0] VGA_IO_LO [VGA_IO_NUM] = '{10'h3B0, 10'h3C0};
    localparam logic [9:0] VGA_IO_HI [VGA_IO_NUM] = '{10'h3BB, 10'h3DF};

    localparam logic [31:0] VGA_MEM_LO = 32'h000A_0000;
    localparam logic [31:0] VGA_MEM_HI = 32'h000B_FFFF;

endpackage

// File: rtl/brd_regfile.sv
module brd_regfile
    import brd_pkg::*;
#(
    parameter int IO_W  = 16,
    parameter int MEM_W = 16,
    parameter int RD_W  = 16,
    parameter int RA_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RA_W-1:0]  addr,
    input  logic [RD_W-1:0]  wdata,
    output logic [RD_W-1:0]  rdata,
    output ctrl_t            ctrl,
    output logic [IO_W-1:0]  io_base,
    output logic [IO_W-1:0]  io_limit,
    output logic [MEM_W-1:0] mem_base,
    output logic [MEM_W-1:0] mem_limit
);

    localparam logic [IO_W-1:0]  IO_BASE_RST  = '1;
    localparam logic [MEM_W-1:0] MEM_BASE_RST = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl      <= '0;
            io_base   <= IO_BASE_RST;
            io_limit  <= '0;
            mem_base  <= MEM_BASE_RST;
            mem_limit <= '0;
        end else if (wr_en) begin
            unique case (addr)
                RA_W'(OFS_CTRL): begin
                    ctrl.vga_en  <= wdata[CTRL_VGA_BIT];
                    ctrl.isa_en  <= wdata[CTRL_ISA_BIT];
                    ctrl.perr_en <= wdata[CTRL_PERR_BIT];
                end
                RA_W'(OFS_IO_BASE):  io_base   <= wdata[IO_W-1:0];
                RA_W'(OFS_IO_LIMIT): io_limit  <= wdata[IO_W-1:0];
                RA_W'(OFS_MEM_BASE): mem_base  <= wdata[MEM_W-1:0];
                RA_W'(OFS_MEM_LIM):  mem_limit <= wdata[MEM_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            RA_W'(OFS_CTRL): begin
                rdata[CTRL_VGA_BIT]  = ctrl.vga_en;
                rdata[CTRL_ISA_BIT]  = ctrl.isa_en;
                rdata[CTRL_PERR_BIT] = ctrl.perr_en;
            end
            RA_W'(OFS_IO_BASE):  rdata = RD_W'(io_base);
            RA_W'(OFS_IO_LIMIT): rdata = RD_W'(io_limit);
            RA_W'(OFS_MEM_BASE): rdata = RD_W'(mem_base);
            RA_W'(OFS_MEM_LIM):  rdata = RD_W'(mem_limit);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/brd_addr_decode.sv
module brd_addr_decode
    import brd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IO_W   = 16,
    parameter int MEM_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_io,
    input  ctrl_t             ctrl,
    input  logic [IO_W-1:0]   io_base,
    input  logic [IO_W-1:0]   io_limit,
    input  logic [MEM_W-1:0]  mem_base,
    input  logic [MEM_W-1:0]  mem_limit,
    output logic              to_secondary
);

    localparam logic [ADDR_W-1:0] VMEM_LO = ADDR_W'(VGA_MEM_LO);
    localparam logic [ADDR_W-1:0] VMEM_HI = ADDR_W'(VGA_MEM_HI);

    logic [IO_W-1:0]       io_ofs;
    logic [MEM_W-1:0]      mem_gran;
    logic [9:0]            alias_ofs;
    logic [VGA_IO_NUM-1:0] vga_io_hit;
    logic                  io_in_win;
    logic                  isa_hole;
    logic                  vga_io;
    logic                  mem_in_win;
    logic                  vga_mem;

    assign io_ofs    = addr[IO_W-1:0];
    assign mem_gran  = addr[ADDR_W-1 -: MEM_W];
    assign alias_ofs = addr[9:0];

    for (genvar g = 0; g < VGA_IO_NUM; g++) begin : g_vga_io
        assign vga_io_hit[g] = (alias_ofs >= VGA_IO_LO[g]) && (alias_ofs <= VGA_IO_HI[g]);
    end

    always_comb begin
        io_in_win    = (io_ofs >= io_base) && (io_ofs <= io_limit);
        isa_hole     = ctrl.isa_en && (addr[9:8] != 2'b00);
        vga_io       = ctrl.vga_en && (|vga_io_hit);
        mem_in_win   = (mem_gran >= mem_base) && (mem_gran <= mem_limit);
        vga_mem      = ctrl.vga_en && (addr >= VMEM_LO) && (addr <= VMEM_HI);
        if (is_io) begin
            to_secondary = vga_io || (io_in_win && !isa_hole);
        end else begin
            to_secondary = vga_mem || mem_in_win;
        end
    end

endmodule

// File: rtl/brd_route_fsm.sv
module brd_route_fsm
    import brd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_is_write,
    input  logic route_in,
    output logic rsp_valid,
    output logic rsp_to_secondary,
    output logic rsp_is_write
);

    route_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;
            ST_RESP: if (!req_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_to_secondary <= 1'b0;
            rsp_is_write     <= 1'b0;
        end else if (req_valid) begin
            rsp_to_secondary <= route_in;
            rsp_is_write     <= req_is_write;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/bridge_route_decoder.sv
module bridge_route_decoder
    import brd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IO_W   = 16,
    parameter int MEM_W  = 16,
    parameter int RD_W   = 16,
    parameter int RA_W   = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [RD_W-1:0]   reg_wdata,
    output logic [RD_W-1:0]   reg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_io,
    input  logic              req_is_write,
    output logic              rsp_valid,
    output logic              rsp_to_secondary,
    output logic              rsp_is_write,
    input  logic              sec_abort,
    input  logic [DATA_W-1:0] sec_rdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              sec_wr_req,
    output logic              sec_wr_commit,
    input  logic              sec_par_err,
    input  logic              serr_enable,
    input  logic              other_err,
    output logic              serr_req
);

    ctrl_t             ctrl_q;
    logic [IO_W-1:0]   io_base_q, io_limit_q;
    logic [MEM_W-1:0]  mem_base_q, mem_limit_q;
    logic              route_d;

    brd_regfile #(
        .IO_W (IO_W), .MEM_W(MEM_W), .RD_W(RD_W), .RA_W(RA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ctrl     (ctrl_q),
        .io_base  (io_base_q),
        .io_limit (io_limit_q),
        .mem_base (mem_base_q),
        .mem_limit(mem_limit_q)
    );

    brd_addr_decode #(
        .ADDR_W(ADDR_W), .IO_W(IO_W), .MEM_W(MEM_W)
    ) u_dec (
        .addr        (req_addr),
        .is_io       (req_is_io),
        .ctrl        (ctrl_q),
        .io_base     (io_base_q),
        .io_limit    (io_limit_q),
        .mem_base    (mem_base_q),
        .mem_limit   (mem_limit_q),
        .to_secondary(route_d)
    );

    brd_route_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_is_write    (req_is_write),
        .route_in        (route_d),
        .rsp_valid       (rsp_valid),
        .rsp_to_secondary(rsp_to_secondary),
        .rsp_is_write    (rsp_is_write)
    );

    // Master abort mode is fixed at zero: all-ones reads, dropped writes.
    assign host_rdata    = sec_abort ? '1 : sec_rdata;
    assign sec_wr_commit = sec_wr_req && !sec_abort;

    assign serr_req = (sec_par_err && ctrl_q.perr_en && serr_enable) || other_err;

endmodule

// File: rtl/brd_checker.sv
module brd_checker
    import brd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RD_W   = 16,
    parameter int RA_W   = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RA_W-1:0]   reg_addr,
    input logic [RD_W-1:0]   reg_rdata,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_is_io,
    input logic              rsp_valid,
    input logic              rsp_to_secondary,
    input logic              sec_abort,
    input logic [DATA_W-1:0] host_rdata,
    input logic              sec_wr_commit,
    input logic              sec_par_err,
    input logic              serr_enable,
    input logic              other_err,
    input logic              serr_req,
    input ctrl_t             ctrl_q
);

    localparam logic [ADDR_W-1:0] VLO = ADDR_W'(VGA_MEM_LO);
    localparam logic [ADDR_W-1:0] VHI = ADDR_W'(VGA_MEM_HI);

    p_ro_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_W'(OFS_CTRL)) |-> (reg_rdata[7:4] == 4'h0 && !reg_rdata[1]));

    p_rsp_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_vga_mem_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && ctrl_q.vga_en && req_addr >= VLO && req_addr <= VHI)
        |=> rsp_to_secondary);

    p_abort_ones_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sec_abort |-> (host_rdata == '1 && !sec_wr_commit));

    p_serr_gate_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!other_err && !(sec_par_err && serr_enable)) |-> !serr_req);

    p_serr_other_r13: assert property (@(posedge clk) disable iff (!rst_n)
        other_err |-> serr_req);

endmodule

bind bridge_route_decoder brd_checker #(
    .ADDR_W(ADDR_W), .RD_W(RD_W), .RA_W(RA_W), .DATA_W(DATA_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_addr        (reg_addr),
    .reg_rdata       (reg_rdata),
    .req_valid       (req_valid),
    .req_addr        (req_addr),
    .req_is_io       (req_is_io),
    .rsp_valid       (rsp_valid),
    .rsp_to_secondary(rsp_to_secondary),
    .sec_abort       (sec_abort),
    .host_rdata      (host_rdata),
    .sec_wr_commit   (sec_wr_commit),
    .sec_par_err     (sec_par_err),
    .serr_enable     (serr_enable),
    .other_err       (other_err),
    .serr_req        (serr_req),
    .ctrl_q          (ctrl_q)
);

// File: tb/tb_bridge_route_decoder.sv
module tb_bridge_route_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_is_io = 1'b0;
    logic        req_is_write = 1'b0;
    logic        rsp_valid, rsp_to_secondary, rsp_is_write;
    logic        sec_abort = 1'b0;
    logic [31:0] sec_rdata = '0;
    logic [31:0] host_rdata;
    logic        sec_wr_req = 1'b0;
    logic        sec_wr_commit;
    logic        sec_par_err = 1'b0, serr_enable = 1'b0, other_err = 1'b0;
    logic        serr_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bridge_route_decoder dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_is_io(req_is_io), .req_is_write(req_is_write),
        .rsp_valid(rsp_valid), .rsp_to_secondary(rsp_to_secondary),
        .rsp_is_write(rsp_is_write), .sec_abort(sec_abort), .sec_rdata(sec_rdata),
        .host_rdata(host_rdata), .sec_wr_req(sec_wr_req), .sec_wr_commit(sec_wr_commit),
        .sec_par_err(sec_par_err), .serr_enable(serr_enable), .other_err(other_err),
        .serr_req(serr_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [15:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, 32'(reg_rdata), 32'(exp));
    endtask

    // Strobe one request; check rsp_valid and route one clock later.
    task automatic route_check(input string req, input logic [31:0] a, input logic io,
                               input logic wr, input logic exp);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_is_io = io; req_is_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check(req, 32'(rsp_to_secondary), 32'(exp));
        check({req, " dir"}, 32'(rsp_is_write), 32'(wr));
    endtask

    task automatic t_reset;
        check("R3 idle after reset", 32'(rsp_valid), 32'd0);
        rd_check("R1 ctrl reset", 3'd0, 16'h0000);
        rd_check("R2 io base reset", 3'd1, 16'hFFFF);
        rd_check("R2 io limit reset", 3'd2, 16'h0000);
        rd_check("R2 mem base reset", 3'd3, 16'hFFFF);
        rd_check("R2 mem limit reset", 3'd4, 16'h0000);
        route_check("R11 no window io", 32'h0000_03C0, 1'b1, 1'b0, 1'b0);
        route_check("R11 no window mem", 32'h0000_0000, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_ctrl_bits;
        wr_reg(3'd0, 16'hFFFF);
        rd_check("R1 ro bits", 3'd0, 16'h000D);
        wr_reg(3'd0, 16'h0000);
        rd_check("R1 clear", 3'd0, 16'h0000);
    endtask

    task automatic t_rsp_timing;
        @(negedge clk);
        check("R3 no rsp without strobe", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0; req_is_io = 1'b0;
        @(negedge clk);
        check("R3 back-to-back 1", 32'(rsp_valid), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R3 back-to-back 2", 32'(rsp_valid), 32'd1);
        @(negedge clk);
        check("R3 single pulse", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_vga;
        wr_reg(3'd0, 16'h0008);
        route_check("R4 vga mem low", 32'h000A_0000, 1'b0, 1'b0, 1'b1);
        route_check("R4 vga mem high", 32'h000B_FFFF, 1'b0, 1'b1, 1'b1);
        route_check("R4 below vga mem", 32'h0009_FFFF, 1'b0, 1'b0, 1'b0);
        route_check("R4 above vga mem", 32'h000C_0000, 1'b0, 1'b0, 1'b0);
        route_check("R5 vga io 3B0", 32'h0000_03B0, 1'b1, 1'b0, 1'b1);
        route_check("R5 vga io 3BB", 32'h0000_03BB, 1'b1, 1'b0, 1'b1);
        route_check("R5 gap 3BC", 32'h0000_03BC, 1'b1, 1'b0, 1'b0);
        route_check("R5 vga io 3DF", 32'h0000_03DF, 1'b1, 1'b0, 1'b1);
        route_check("R5 past 3DF", 32'h0000_03E0, 1'b1, 1'b0, 1'b0);
        route_check("R5 alias F7C4", 32'h0000_F7C4, 1'b1, 1'b0, 1'b1);
        wr_reg(3'd0, 16'h000C);
        route_check("R6 vga over isa", 32'h0000_13D4, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_vga_off;
        wr_reg(3'd0, 16'h0000);
        route_check("R7 vga off mem", 32'h000A_8000, 1'b0, 1'b0, 1'b0);
        route_check("R7 vga off io", 32'h0000_03C0, 1'b1, 1'b0, 1'b0);
        wr_reg(3'd3, 16'h000A);
        wr_reg(3'd4, 16'h000A);
        route_check("R7 window claims", 32'h000A_8000, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_io_window;
        wr_reg(3'd1, 16'h1000);
        wr_reg(3'd2, 16'h1FFF);
        route_check("R8 io base edge", 32'h0000_1000, 1'b1, 1'b0, 1'b1);
        route_check("R8 io limit edge", 32'h0000_1FFF, 1'b1, 1'b1, 1'b1);
        route_check("R8 below base", 32'h0000_0FFF, 1'b1, 1'b0, 1'b0);
        route_check("R8 above limit", 32'h0000_2000, 1'b1, 1'b0, 1'b0);
        route_check("R9 isa off upper", 32'h0000_1300, 1'b1, 1'b0, 1'b1);
        wr_reg(3'd0, 16'h0004);
        route_check("R9 isa low 256", 32'h0000_14FF, 1'b1, 1'b0, 1'b1);
        route_check("R9 isa hole 100", 32'h0000_1500, 1'b1, 1'b0, 1'b0);
        route_check("R9 isa hole 3FF", 32'h0000_17FF, 1'b1, 1'b0, 1'b0);
        route_check("R9 isa hole no vga", 32'h0000_13C0, 1'b1, 1'b0, 1'b0);
        wr_reg(3'd0, 16'h0000);
    endtask

    task automatic t_mem_window;
        wr_reg(3'd3, 16'h8000);
        wr_reg(3'd4, 16'h80FF);
        rd_check("R2 mem limit rw", 3'd4, 16'h80FF);
        route_check("R10 mem base edge", 32'h8000_0000, 1'b0, 1'b0, 1'b1);
        route_check("R10 mem limit edge", 32'h80FF_FFFF, 1'b0, 1'b0, 1'b1);
        route_check("R10 below", 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0);
        route_check("R10 above", 32'h8100_0000, 1'b0, 1'b0, 1'b0);
        route_check("R11 io not mem", 32'h8000_0000, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_write_next;
        // Strobe in the same cycle as a write: old value applies; the next strobe sees the new one.
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 16'h9000;
        req_valid = 1'b1; req_addr = 32'h8010_0000; req_is_io = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R14 old value same cycle", 32'(rsp_to_secondary), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R14 new value next request", 32'(rsp_to_secondary), 32'd0);
    endtask

    task automatic t_abort;
        @(negedge clk);
        sec_rdata = 32'h1234_5678; sec_wr_req = 1'b1; sec_abort = 1'b0;
        #1;
        check("R12 pass data", host_rdata, 32'h1234_5678);
        check("R12 commit", 32'(sec_wr_commit), 32'd1);
        sec_abort = 1'b1;
        #1;
        check("R12 abort ones", host_rdata, 32'hFFFF_FFFF);
        check("R12 abort drop", 32'(sec_wr_commit), 32'd0);
        sec_abort = 1'b0; sec_wr_req = 1'b0;
    endtask

    task automatic t_serr;
        wr_reg(3'd0, 16'h0000);
        @(negedge clk);
        sec_par_err = 1'b1; serr_enable = 1'b1;
        #1;
        check("R13 perr disabled", 32'(serr_req), 32'd0);
        wr_reg(3'd0, 16'h0001);
        #1;
        check("R13 perr reported", 32'(serr_req), 32'd1);
        serr_enable = 1'b0;
        #1;
        check("R13 serr enable off", 32'(serr_req), 32'd0);
        sec_par_err = 1'b0; other_err = 1'b1;
        wr_reg(3'd0, 16'h0000);
        #1;
        check("R13 other error", 32'(serr_req), 32'd1);
        other_err = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_bits();
        t_rsp_timing();
        t_vga();
        t_vga_off();
        t_io_window();
        t_mem_window();
        t_write_next();
        t_abort();
        t_serr();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule